// File: doc/BRIEF.md
# Line Test Pattern Generator

This block produces the serial transmit bit stream for one T1 or E1 line channel when the line is put into a test condition. A 3-bit mode select chooses what goes out. With its top bit low, ordinary line data passes through. With its top bit high, the block sends one of four test signals: a quasi-random sequence, continuous ones, a repeating loop-up code or a repeating loop-down code. A bit-rate clock enable paces every output bit. The block runs on a faster system clock.

The quasi-random signal depends on the line standard. In T1 mode it is a 20-stage pseudo-random sequence with a limit on zero runs. In E1 mode it is a plain 15-stage sequence. A polarity control can invert the quasi-random signal. A transmitter-on control drives an output-enable flag, which the line driver uses to tri-state its outputs. While the loop-up code is being sent, a flag tells the receive side to ignore automatic loop-code detection, so that the far end answering the request cannot trigger a loop-back on this channel.

Top module: `line_test_pattern_gen`

## Requirements
- R1: While mode_sel[2] is 0 (codes 000 to 011), each clock with bit_en high loads data_in into tx_bit.
- R2: With mode_sel = 101, every bit sent is 1.
- R3: With mode_sel = 100 and e1_sel = 0, the pattern comes from a 20-bit register r that is seeded to all ones. Each bit_en the raw bit is r[19], and r then becomes {r[18:0], r[19]^r[16]}. This is the polynomial x^20+x^17+1.
- R4: In T1 quasi-random mode the pattern bit is forced to 1 when the previous 14 pattern bits since entry were all 0. As a result, the uninverted output never carries more than 14 consecutive zeros.
- R5: With mode_sel = 100 and e1_sel = 1, the pattern comes from a 15-bit register r that is seeded to all ones. Each bit_en the bit is r[14], and r then becomes {r[13:0], r[14]^r[13]}. This is the polynomial x^15+x^14+1, and no zero limiting is applied.
- R6: In quasi-random mode, qrs_invert = 1 inverts each transmitted bit and qrs_invert = 0 leaves it unchanged. The invert control has no effect in any other mode.
- R7: With mode_sel = 110, the bits 0,0,0,0,1 are sent in that order, repeating.
- R8: With mode_sel = 111, the bits 0,0,1 are sent in that order, repeating.
- R9: A change of mode_sel or e1_sel reseeds the generator, clears the zero-run count and restarts the loop codes. The first bit_en at or after the clock of the change sends the first bit of the new pattern.
- R10: tx_bit changes only on a clock edge where bit_en is high, and it holds its value otherwise.
- R11: loop_det_suppress is 1 exactly in the cycles that follow a clock where mode_sel was 110.
- R12: tx_oe equals the value tx_on had at the previous clock edge. A low tx_oe tri-states the line driver.
- R13: During reset, tx_bit, tx_oe and loop_det_suppress are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bit_en | input | 1 | Bit-rate clock enable |
| mode_sel | input | 3 | Test pattern select |
| e1_sel | input | 1 | 1 selects E1 line rules, 0 selects T1 |
| qrs_invert | input | 1 | Inverts the quasi-random pattern |
| tx_on | input | 1 | Transmitter enable |
| data_in | input | 1 | Normal line data |
| tx_bit | output | 1 | Serial transmit bit |
| tx_oe | output | 1 | Line driver output enable |
| loop_det_suppress | output | 1 | Tells the receive side to ignore automatic loop-code detection |

## Verification
The assertions assume that every control input is synchronous to clk and changes only between edges. They also assume that qrs_invert, e1_sel and mode_sel define the pattern in force at the edge where they are sampled. The zero-run check further assumes that a change to any of these controls starts a new run. To stay inside these assumptions, the bench drives every input on the falling edge only. It holds the controls for random-length segments and toggles bit_en and data_in freely inside each segment. It compares results one time unit after the rising edge.

// File: rtl/line_test_pattern_gen.sv
module line_test_pattern_gen #(
  parameter int T1_LEN  = 20,
  parameter int T1_TAP  = 17,
  parameter int E1_LEN  = 15,
  parameter int E1_TAP  = 14,
  parameter int ZRUN_MAX = 14
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       bit_en,
  input  logic [2:0] mode_sel,
  input  logic       e1_sel,
  input  logic       qrs_invert,
  input  logic       tx_on,
  input  logic       data_in,
  output logic       tx_bit,
  output logic       tx_oe,
  output logic       loop_det_suppress
);
  localparam int ZW = $clog2(ZRUN_MAX + 1);
  localparam logic [2:0] M_QRS  = 3'b100;
  localparam logic [2:0] M_ONES = 3'b101;
  localparam logic [2:0] M_LUP  = 3'b110;
  localparam logic [2:0] M_LDN  = 3'b111;
  localparam logic [T1_LEN-1:0] SEED = '1;

  logic [2:0]        mode_q;
  logic              e1_q;
  logic [2:0]        cnt, cnt_cur, cnt_nxt, cnt_lim;
  logic [T1_LEN-1:0] lf, lf_cur, lf_nxt;
  logic [ZW-1:0]     zrun, z_cur;
  logic              chg, raw, fb, lim_bit, nxt_bit;

  assign chg     = (mode_sel != mode_q) || (e1_sel != e1_q);
  assign cnt_cur = chg ? 3'd0 : cnt;
  assign lf_cur  = chg ? SEED : lf;
  assign z_cur   = chg ? '0 : zrun;

  assign cnt_lim = (mode_sel == M_LUP) ? 3'd4 : 3'd2;
  assign cnt_nxt = (cnt_cur >= cnt_lim) ? 3'd0 : cnt_cur + 3'd1;

  assign raw     = e1_sel ? lf_cur[E1_LEN-1] : lf_cur[T1_LEN-1];
  assign fb      = e1_sel ? (lf_cur[E1_LEN-1] ^ lf_cur[E1_TAP-1])
                          : (lf_cur[T1_LEN-1] ^ lf_cur[T1_TAP-1]);
  assign lf_nxt  = {lf_cur[T1_LEN-2:0], fb};
  assign lim_bit = raw | (!e1_sel && z_cur == ZW'(ZRUN_MAX));

  always_comb begin
    case (mode_sel)
      M_QRS:   nxt_bit = lim_bit ^ qrs_invert;
      M_ONES:  nxt_bit = 1'b1;
      M_LUP:   nxt_bit = (cnt_cur == 3'd4);
      M_LDN:   nxt_bit = (cnt_cur == 3'd2);
      default: nxt_bit = data_in;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mode_q            <= '0;
      e1_q              <= 1'b0;
      cnt               <= '0;
      lf                <= SEED;
      zrun              <= '0;
      tx_bit            <= 1'b0;
      tx_oe             <= 1'b0;
      loop_det_suppress <= 1'b0;
    end else begin
      mode_q            <= mode_sel;
      e1_q              <= e1_sel;
      tx_oe             <= tx_on;
      loop_det_suppress <= (mode_sel == M_LUP);
      if (bit_en) begin
        tx_bit <= nxt_bit;
        cnt    <= cnt_nxt;
        lf     <= lf_nxt;
        zrun   <= lim_bit ? '0 : z_cur + ZW'(1);
      end else if (chg) begin
        cnt  <= '0;
        lf   <= SEED;
        zrun <= '0;
      end
    end
  end
endmodule

// File: rtl/line_test_pattern_gen_chk.sv
module line_test_pattern_gen_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       bit_en,
  input logic [2:0] mode_sel,
  input logic       e1_sel,
  input logic       qrs_invert,
  input logic       tx_on,
  input logic       data_in,
  input logic       tx_bit,
  input logic       tx_oe,
  input logic       loop_det_suppress
);
  logic       t1_plain, upd_q, cfg_chg;
  logic [2:0] mode_p;
  logic       e1_p, inv_p;
  logic [4:0] zc;

  assign t1_plain = (mode_sel == 3'b100) && !e1_sel && !qrs_invert;
  assign cfg_chg  = (mode_sel != mode_p) || (e1_sel != e1_p) || (qrs_invert != inv_p);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      upd_q  <= 1'b0;
      zc     <= '0;
      mode_p <= '0;
      e1_p   <= 1'b0;
      inv_p  <= 1'b0;
    end else begin
      mode_p <= mode_sel;
      e1_p   <= e1_sel;
      inv_p  <= qrs_invert;
      upd_q  <= bit_en && t1_plain;
      if (!t1_plain || cfg_chg) zc <= '0;
      else if (upd_q) zc <= tx_bit ? 5'd0 : zc + 5'd1;
    end
  end

  p_zero_run_r4: assert property (@(posedge clk) disable iff (!rst_n) zc <= 5'd14);

  p_pass_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (bit_en && !mode_sel[2]) |=> (tx_bit == $past(data_in)));

  p_ones_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (bit_en && mode_sel == 3'b101) |=> tx_bit);

  p_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !bit_en |=> $stable(tx_bit));

  p_suppress_on_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_sel == 3'b110) |=> loop_det_suppress);

  p_suppress_off_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_sel != 3'b110) |=> !loop_det_suppress);

  p_oe_r12: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (tx_oe == $past(tx_on)));
endmodule

bind line_test_pattern_gen line_test_pattern_gen_chk u_chk (.*);

// File: tb/tb_line_test_pattern_gen.sv
module tb_line_test_pattern_gen;
  logic clk = 0, rst_n = 0, bit_en = 0, e1_sel = 0, qrs_invert = 0, tx_on = 0, data_in = 0;
  logic [2:0] mode_sel = 0;
  logic tx_bit, tx_oe, loop_det_suppress;

  int n_tests = 0, n_fail = 0;
  bit done = 0;

  // model state
  logic [2:0]  m_mode;
  logic        m_e1, m_bit;
  int          m_cnt, m_zrun;
  logic [19:0] m_lf;
  int          zrun_obs;

  always #4 clk = ~clk;

  line_test_pattern_gen dut (.*);

  task automatic check(string req, logic act, logic exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %b expected %b at %0t", req, act, exp, $time);
    end
  endtask

  function automatic string tag_of(logic [2:0] m, logic e1, logic inv);
    if (!m[2]) return "R1";
    if (m == 3'b101) return "R2";
    if (m == 3'b110) return "R7";
    if (m == 3'b111) return "R8";
    if (inv) return "R6";
    return e1 ? "R5" : "R3";
  endfunction

  function automatic logic exp_bit(input logic [2:0] m, input logic e1, input logic inv,
                                   input logic din, input int c, input logic [19:0] lf,
                                   input int z);
    logic r;
    r = e1 ? lf[14] : lf[19];
    if (!e1 && z == 14) r = 1'b1;
    case (m)
      3'b100: return r ^ inv;
      3'b101: return 1'b1;
      3'b110: return c == 4;
      3'b111: return c == 2;
      default: return din;
    endcase
  endfunction

  task automatic model_reset();
    m_mode = 0; m_e1 = 0; m_cnt = 0; m_lf = '1; m_zrun = 0; m_bit = 0; zrun_obs = 0;
  endtask

  // R9: change of mode or line standard restarts everything
  task automatic model_step();
    int c, z; logic [19:0] lf; logic r, fb; bit chg;
    chg = (mode_sel != m_mode) || (e1_sel != m_e1);
    c  = chg ? 0 : m_cnt;
    lf = chg ? '1 : m_lf;
    z  = chg ? 0 : m_zrun;
    if (chg) zrun_obs = 0;
    if (bit_en) begin
      m_bit = exp_bit(mode_sel, e1_sel, qrs_invert, data_in, c, lf, z);
      r  = e1_sel ? lf[14] : lf[19];
      if (!e1_sel && z == 14) r = 1'b1;
      fb = e1_sel ? (lf[14] ^ lf[13]) : (lf[19] ^ lf[16]);
      m_lf   = {lf[18:0], fb};
      m_zrun = r ? 0 : z + 1;
      m_cnt  = (c >= ((mode_sel == 3'b110) ? 4 : 2)) ? 0 : c + 1;
    end else begin
      m_lf = lf; m_zrun = z; m_cnt = c;
    end
    m_mode = mode_sel; m_e1 = e1_sel;
  endtask

  task automatic cycle();
    logic [2:0] mm; logic ee, ii, en, on;
    mm = mode_sel; ee = e1_sel; ii = qrs_invert; en = bit_en; on = tx_on;
    model_step();
    @(posedge clk); #1;
    check(tag_of(mm, ee, ii), tx_bit, m_bit);
    check("R12", tx_oe, on);
    check("R11", loop_det_suppress, mm == 3'b110);
    if (mm == 3'b100 && !ee && !ii && en) begin
      zrun_obs = tx_bit ? 0 : zrun_obs + 1;
      n_tests++;
      if (zrun_obs > 14) begin
        n_fail++;
        $display("FAIL R4: actual zero run %0d expected <= 14", zrun_obs);
      end
    end
    @(negedge clk);
  endtask

  task automatic seg(logic [2:0] m, logic e1, logic inv, int len, int en_pct);
    mode_sel = m; e1_sel = e1; qrs_invert = inv;
    for (int i = 0; i < len; i++) begin
      bit_en  = ($urandom % 100) < en_pct;
      data_in = $urandom;
      tx_on   = ($urandom % 8) != 0;
      cycle();
    end
  endtask

  initial begin
    logic [2:0] rm;
    void'($urandom(32'd20240611));
    model_reset();
    rst_n = 0; tx_on = 1; bit_en = 1; mode_sel = 3'b101;
    repeat (3) @(posedge clk);
    #1;
    check("R13", tx_bit, 1'b0);
    check("R13", tx_oe, 1'b0);
    check("R13", loop_det_suppress, 1'b0);
    @(negedge clk);
    rst_n = 1; bit_en = 0; mode_sel = 0; tx_on = 0;

    // directed: loop-up sequence (R7), loop-down (R8), all ones (R2)
    seg(3'b110, 0, 0, 20, 100);
    seg(3'b111, 0, 1, 15, 100);
    seg(3'b101, 1, 1, 10, 100);
    // R10: hold with bit_en low across a mode change, then restart (R9)
    seg(3'b110, 0, 0, 7, 100);
    seg(3'b111, 0, 0, 5, 0);
    seg(3'b111, 0, 0, 9, 100);
    // R5 and R3 from seed, and R6 inverted
    seg(3'b100, 1, 0, 100, 100);
    seg(3'b100, 0, 0, 100, 100);
    seg(3'b100, 0, 1, 60, 100);
    // long T1 stretch exercising the zero limiter (R4)
    seg(3'b100, 0, 0, 60000, 100);
    // constrained random segments
    for (int s = 0; s < 120; s++) begin
      rm = $urandom % 8;
      seg(rm, $urandom % 2, $urandom % 2, 20 + $urandom % 300, 30 + $urandom % 71);
    end
    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    #1600000;
    if (!done) begin
      n_tests++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end
endmodule